// File: doc/BRIEF.md
# Packed Double-Precision Horizontal Subtract Unit

The unit takes two packed vectors of IEEE-754 double-precision numbers and, inside every 128-bit section, subtracts the upper double of a source from the lower double of the same source. In each 128-bit section, the difference from the first source fills the lower 64-bit slot of the result and the difference from the second source fills the upper slot. A 2-bit mode selects one of three forms. The first is a 128-bit form where the destination is also the first source, so the destination bits above 127 keep their old contents. The second is a 128-bit form that clears those upper bits. The third is a full 256-bit form with two independent 128-bit sections.

The unit contains its own double-precision subtractor with round-to-nearest-even. It handles NaN and infinity inputs, and it keeps sticky exception flags that collect over the lanes in use. In the keep-upper mode, a second operand that comes from memory must sit on a 16-byte boundary. If it does not, the unit raises a general-protection fault and leaves the destination as it was. Operands, the memory flag and the operand address all arrive as plain inputs. The result is registered and appears one cycle after a valid input.

Top module: `hsub_unit`

## Requirements
- R1: result[63:0] = src1[63:0] − src1[127:64] and result[127:64] = src2[63:0] − src2[127:64], each as an IEEE-754 double with round-to-nearest-even.
- R2: When mode bit 1 is set (codes 2'b10 and 2'b11), result[191:128] = src1[191:128] − src1[255:192] and result[255:192] = src2[191:128] − src2[255:192]. No value crosses between the two 128-bit sections.
- R3: Mode 2'b00 (keep-upper) outputs result[255:128] = src1[255:128].
- R4: Mode 2'b01 (zero-upper) outputs result[255:128] = 0.
- R5: In mode 2'b00, when src2_mem = 1 and src2_addr[3:0] ≠ 0, fault_gp goes high with the result. The whole result then equals src1, and the flags are left as they were. No fault arises in any other mode or for an aligned address.
- R6: Rounding is to nearest, with ties going to the even value. A zero difference of equal nonzero values is +0. Zero minus zero follows the IEEE sign rules, so −0 − +0 = −0 and every other zero pair gives +0.
- R7: If either input of a lane is NaN, the result is the low-half NaN when that one is a NaN, and otherwise the high-half NaN. The chosen NaN keeps its own sign and gets fraction bit 51 set. An input signalling NaN (bit 51 clear) sets the invalid flag.
- R8: Infinity minus infinity of the same sign gives 64'hFFF8_0000_0000_0000 and sets invalid. In any other case, an infinite minuend passes through unchanged, and an infinite subtrahend comes out with its sign flipped.
- R9: A finite difference whose magnitude rounds beyond the largest finite double gives infinity with the sign of the exact difference, and sets the overflow and precision flags.
- R10: The denormal flag is set when an input of a lane is subnormal and neither input of that lane is NaN. The underflow flag needs a result that is both tiny and inexact, so subnormal differences (always exact) leave it clear.
- R11: flags bits are [0] invalid, [1] denormal, [2] overflow, [3] underflow, [4] precision. Each bit is the sticky OR over the active lanes of accepted, non-faulting inputs. The lanes above bit 127 count only when mode bit 1 is set. flags_clr clears the old value, and flags raised by an input in that same cycle are still kept.
- R12: out_valid is high exactly one cycle after in_valid. When no valid input arrives, result, fault_gp and flags hold, and out_valid is low. Reset clears result, out_valid, fault_gp and flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands and mode are valid this cycle |
| mode | input | 2 | 00 keep-upper 128, 01 zero-upper 128, 1x full 256 |
| src1 | input | 256 | First source, also the prior destination |
| src2 | input | 256 | Second source |
| src2_mem | input | 1 | Second source was read from memory |
| src2_addr | input | 48 | Byte address of the second source |
| flags_clr | input | 1 | Clear the sticky exception flags |
| out_valid | output | 1 | Result valid |
| result | output | 256 | Packed differences |
| fault_gp | output | 1 | Misaligned memory operand fault for this result |
| flags | output | 5 | Sticky exception flags |

## Verification
Faults in operand swap, alignment shift or normalisation show up as wrong result bits in the cycle after the input is accepted. Only some operand pairs expose them, so the stimulus mixes near-equal values, widely separated exponents, subnormals and specials. A wrong lane-activity mask or a corrupted sticky register leaves a wrong flags value that lasts until the next clear. A mode decode fault shows only in the upper 128 result bits or in fault_gp, so every mode is exercised with both aligned and misaligned memory addresses.

// File: rtl/hsub_pkg.sv
package hsub_pkg;

   typedef enum logic [1:0] {
      HS_KEEP     = 2'b00,
      HS_ZERO     = 2'b01,
      HS_WIDE     = 2'b10,
      HS_WIDE_ALT = 2'b11
   } hs_mode_e;

   localparam int unsigned HS_FLAG_W = 5;
   localparam int unsigned FLG_INV   = 0;
   localparam int unsigned FLG_DEN   = 1;
   localparam int unsigned FLG_OFL   = 2;
   localparam int unsigned FLG_UFL   = 3;
   localparam int unsigned FLG_PREC  = 4;

endpackage

// File: rtl/hsub_dp_sub.sv
module hsub_dp_sub
   import hsub_pkg::*;
#(
   parameter int unsigned EXP_W  = 11,
   parameter int unsigned FRAC_W = 52
) (
   input  logic [EXP_W+FRAC_W:0] op_a,
   input  logic [EXP_W+FRAC_W:0] op_b,
   output logic [EXP_W+FRAC_W:0] diff,
   output logic [HS_FLAG_W-1:0]  exc
);
   localparam int unsigned DW = 1 + EXP_W + FRAC_W;
   localparam int unsigned MW = FRAC_W + 1;
   localparam int unsigned XW = MW + 3;
   localparam int unsigned EW = EXP_W + 2;
   localparam logic [EXP_W-1:0] EMAX = '1;

   if (EXP_W < 2 || FRAC_W < 2) begin : g_bad_fmt
      $error("hsub_dp_sub: format too narrow");
   end

   function automatic int unsigned lzc(input logic [XW-1:0] v);
      int unsigned n = 0;
      logic seen = 1'b0;
      for (int i = XW - 1; i >= 0; i--) begin
         if (!seen && !v[i]) n++;
         else seen = 1'b1;
      end
      return n;
   endfunction

   logic              a_s, b_s, x_s, y_s, eff_sub, swap;
   logic [EXP_W-1:0]  a_e, b_e, x_e, y_e;
   logic [FRAC_W-1:0] a_f, b_f, x_f, y_f, fr;
   logic              a_nan, b_nan, a_snan, b_snan, a_inf, b_inf, a_den, b_den;
   logic [EW-1:0]     ex, ey, d, d_cl, lz, sh, e_pre, ef;
   logic [MW-1:0]     mx, my, mant;
   logic [2*XW-1:0]   aligned_w;
   logic [XW-1:0]     al, norm;
   logic [XW:0]       sum;
   logic [MW:0]       mr;
   logic              g, r, st, inexact, up, tiny, ofl;

   // operand classification and magnitude ordering
   always_comb begin
      a_s = op_a[DW-1];
      a_e = op_a[DW-2 -: EXP_W];
      a_f = op_a[FRAC_W-1:0];
      b_s = ~op_b[DW-1];
      b_e = op_b[DW-2 -: EXP_W];
      b_f = op_b[FRAC_W-1:0];

      a_nan  = (a_e == EMAX) && (a_f != '0);
      b_nan  = (b_e == EMAX) && (b_f != '0);
      a_snan = a_nan && !a_f[FRAC_W-1];
      b_snan = b_nan && !b_f[FRAC_W-1];
      a_inf  = (a_e == EMAX) && (a_f == '0);
      b_inf  = (b_e == EMAX) && (b_f == '0);
      a_den  = (a_e == '0) && (a_f != '0);
      b_den  = (b_e == '0) && (b_f != '0);

      swap = op_b[DW-2:0] > op_a[DW-2:0];
      x_s  = swap ? b_s : a_s;
      y_s  = swap ? a_s : b_s;
      x_e  = swap ? b_e : a_e;
      y_e  = swap ? a_e : b_e;
      x_f  = swap ? b_f : a_f;
      y_f  = swap ? a_f : b_f;
      eff_sub = x_s ^ y_s;
   end

   // alignment and add/subtract of magnitudes
   always_comb begin
      ex = (x_e == '0) ? EW'(1) : EW'(x_e);
      ey = (y_e == '0) ? EW'(1) : EW'(y_e);
      mx = {(x_e != '0), x_f};
      my = {(y_e != '0), y_f};
      d    = ex - ey;
      d_cl = (d > EW'(XW)) ? EW'(XW) : d;
      aligned_w = {my, 3'b000, {XW{1'b0}}} >> d_cl;
      al = aligned_w[2*XW-1:XW];
      al[0] = al[0] | (|aligned_w[XW-1:0]);
      if (eff_sub) sum = {1'b0, mx, 3'b000} - {1'b0, al};
      else         sum = {1'b0, mx, 3'b000} + {1'b0, al};
   end

   // normalisation and round-to-nearest-even
   always_comb begin
      lz = EW'(lzc(sum[XW-1:0]));
      sh = '0;
      if (sum[XW]) begin
         norm  = {sum[XW:2], |sum[1:0]};
         e_pre = ex + EW'(1);
      end else begin
         sh    = (lz < ex - EW'(1)) ? lz : (ex - EW'(1));
         norm  = sum[XW-1:0] << sh;
         e_pre = ex - sh;
      end
      mant    = norm[XW-1:3];
      g       = norm[2];
      r       = norm[1];
      st      = norm[0];
      tiny    = !norm[XW-1];
      inexact = g | r | st;
      up      = g & (r | st | mant[0]);
      mr      = {1'b0, mant} + {{MW{1'b0}}, up};
      if (mr[MW]) begin
         ef = e_pre + EW'(1);
         fr = '0;
      end else begin
         ef = mr[MW-1] ? e_pre : '0;
         fr = mr[FRAC_W-1:0];
      end
      ofl = ef >= EW'(EMAX);
   end

   // special-value selection
   always_comb begin
      exc = '0;
      if (a_nan || b_nan) begin
         diff = a_nan ? {op_a[DW-1], a_e, 1'b1, a_f[FRAC_W-2:0]}
                      : {op_b[DW-1], b_e, 1'b1, b_f[FRAC_W-2:0]};
         exc[FLG_INV] = a_snan | b_snan;
      end else begin
         exc[FLG_DEN] = a_den | b_den;
         if (a_inf && b_inf && (a_s != b_s)) begin
            diff = {1'b1, EMAX, 1'b1, {(FRAC_W-1){1'b0}}};
            exc[FLG_INV] = 1'b1;
         end else if (a_inf) begin
            diff = op_a;
         end else if (b_inf) begin
            diff = {b_s, op_b[DW-2:0]};
         end else if (sum == '0) begin
            diff = {(eff_sub ? 1'b0 : x_s), {(DW-1){1'b0}}};
         end else if (ofl) begin
            diff = {x_s, EMAX, {FRAC_W{1'b0}}};
            exc[FLG_OFL]  = 1'b1;
            exc[FLG_PREC] = 1'b1;
         end else begin
            diff = {x_s, ef[EXP_W-1:0], fr};
            exc[FLG_PREC] = inexact;
            exc[FLG_UFL]  = tiny & inexact;
         end
      end
   end

   always_comb begin
      a_r9_ovf_inf: assert (!exc[FLG_OFL] || diff[DW-2:0] == {EMAX, {FRAC_W{1'b0}}})
         else $error("overflow flag without infinite result");
      a_r10_ufl_prec: assert (!exc[FLG_UFL] || exc[FLG_PREC])
         else $error("underflow flag without precision flag");
      a_r8_inv_qnan: assert (!exc[FLG_INV] || (diff[DW-2 -: EXP_W] == EMAX && diff[FRAC_W-1]))
         else $error("invalid flag without quiet NaN result");
   end

endmodule

// File: rtl/hsub_align_chk.sv
module hsub_align_chk
   import hsub_pkg::*;
#(
   parameter int unsigned ADDR_W      = 48,
   parameter int unsigned ALIGN_BYTES = 16
) (
   input  logic [1:0]        mode,
   input  logic              mem_op,
   input  logic [ADDR_W-1:0] addr,
   output logic              fault
);
   localparam int unsigned LSB = $clog2(ALIGN_BYTES);

   if ((1 << LSB) != ALIGN_BYTES) begin : g_bad_align
      $error("hsub_align_chk: ALIGN_BYTES must be a power of two");
   end
   if (LSB >= ADDR_W) begin : g_bad_addr
      $error("hsub_align_chk: address narrower than alignment");
   end

   if (LSB == 0) begin : g_no_check
      logic unused_in;
      assign unused_in = ^{mode, mem_op, addr};
      assign fault = 1'b0;
   end else begin : g_check
      logic unused_hi;
      assign unused_hi = ^addr[ADDR_W-1:LSB];
      assign fault = (mode == HS_KEEP) && mem_op && (addr[LSB-1:0] != '0);
   end

endmodule

// File: rtl/hsub_lanes.sv
module hsub_lanes
   import hsub_pkg::*;
#(
   parameter int unsigned VEC_W  = 256,
   parameter int unsigned EXP_W  = 11,
   parameter int unsigned FRAC_W = 52
) (
   input  logic [VEC_W-1:0]     src1,
   input  logic [VEC_W-1:0]     src2,
   input  logic                 wide,
   output logic [VEC_W-1:0]     lanes,
   output logic [HS_FLAG_W-1:0] lane_flags
);
   localparam int unsigned DW  = 1 + EXP_W + FRAC_W;
   localparam int unsigned PW  = 2 * DW;
   localparam int unsigned NCH = VEC_W / PW;
   localparam int unsigned NL  = 2 * NCH;

   logic [HS_FLAG_W-1:0] exc_l [NL];
   logic [NL-1:0]        act;

   for (genvar k = 0; k < NL; k++) begin : g_lane
      localparam int unsigned CH = k / 2;
      logic [PW-1:0] pair;
      if (k % 2 == 0) begin : g_s1
         assign pair = src1[CH*PW +: PW];
      end else begin : g_s2
         assign pair = src2[CH*PW +: PW];
      end
      hsub_dp_sub #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_sub (
         .op_a (pair[DW-1:0]),
         .op_b (pair[PW-1:DW]),
         .diff (lanes[k*DW +: DW]),
         .exc  (exc_l[k])
      );
      assign act[k] = (CH == 0) || wide;
   end

   always_comb begin
      lane_flags = '0;
      for (int k = 0; k < NL; k++) begin
         if (act[k]) lane_flags = lane_flags | exc_l[k];
      end
   end

endmodule

// File: rtl/hsub_unit.sv
module hsub_unit
   import hsub_pkg::*;
#(
   parameter int unsigned VEC_W       = 256,
   parameter int unsigned EXP_W       = 11,
   parameter int unsigned FRAC_W      = 52,
   parameter int unsigned ADDR_W      = 48,
   parameter int unsigned ALIGN_BYTES = 16,
   parameter bit          OUT_REG     = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   input  logic [1:0]           mode,
   input  logic [VEC_W-1:0]     src1,
   input  logic [VEC_W-1:0]     src2,
   input  logic                 src2_mem,
   input  logic [ADDR_W-1:0]    src2_addr,
   input  logic                 flags_clr,
   output logic                 out_valid,
   output logic [VEC_W-1:0]     result,
   output logic                 fault_gp,
   output logic [HS_FLAG_W-1:0] flags
);
   localparam int unsigned DW    = 1 + EXP_W + FRAC_W;
   localparam int unsigned LOW_W = 2 * DW;

   if (VEC_W % LOW_W != 0 || VEC_W < 2 * LOW_W) begin : g_bad_vec
      $error("hsub_unit: VEC_W must be a multiple of two pairs");
   end

   logic [VEC_W-1:0]     lanes, nxt_res;
   logic [HS_FLAG_W-1:0] lane_flags, flags_q;
   logic                 wide, fault_c;

   assign wide = mode[1];

   hsub_lanes #(.VEC_W(VEC_W), .EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_lanes (
      .src1       (src1),
      .src2       (src2),
      .wide       (wide),
      .lanes      (lanes),
      .lane_flags (lane_flags)
   );

   hsub_align_chk #(.ADDR_W(ADDR_W), .ALIGN_BYTES(ALIGN_BYTES)) u_align (
      .mode   (mode),
      .mem_op (src2_mem),
      .addr   (src2_addr),
      .fault  (fault_c)
   );

   always_comb begin
      nxt_res = lanes;
      if (!wide) begin
         nxt_res[VEC_W-1:LOW_W] = (mode == HS_KEEP) ? src1[VEC_W-1:LOW_W] : '0;
      end
      if (fault_c) nxt_res = src1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) flags_q <= '0;
      else flags_q <= (flags_clr ? '0 : flags_q) |
                      ((in_valid && !fault_c) ? lane_flags : '0);
   end
   assign flags = flags_q;

   if (OUT_REG) begin : g_reg
      logic [VEC_W-1:0] res_q;
      logic             vld_q, flt_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            res_q <= '0;
            vld_q <= 1'b0;
            flt_q <= 1'b0;
         end else begin
            vld_q <= in_valid;
            if (in_valid) begin
               res_q <= nxt_res;
               flt_q <= fault_c;
            end
         end
      end
      assign result    = res_q;
      assign out_valid = vld_q;
      assign fault_gp  = flt_q;

      a_r12_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid |=> out_valid);
      a_r12_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
         !in_valid |=> (!out_valid && $stable(result) && $stable(fault_gp)));
      a_r5_fault_src1: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid |=> (!fault_gp || result == $past(src1)));
      a_r5_keep_only: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && mode != HS_KEEP) |=> !fault_gp);
      a_r4_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && mode == HS_ZERO) |=> (result[VEC_W-1:LOW_W] == '0));
      a_r3_upper_keep: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && mode == HS_KEEP) |=> (result[VEC_W-1:LOW_W] == $past(src1[VEC_W-1:LOW_W])));
   end else begin : g_comb
      assign result    = nxt_res;
      assign out_valid = in_valid;
      assign fault_gp  = in_valid && fault_c;
   end

   a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      !flags_clr |=> ((flags & $past(flags)) == $past(flags)));
   a_r11_no_change_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!flags_clr && !in_valid) |=> $stable(flags));

endmodule

// File: tb/hsub_unit_test.sv
`timescale 1ns/1ps
module hsub_unit_test;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic [1:0]   mode = 2'b00;
   logic [255:0] src1 = '0, src2 = '0;
   logic         src2_mem = 1'b0;
   logic [47:0]  src2_addr = '0;
   logic         flags_clr = 1'b0;
   logic         out_valid, fault_gp;
   logic [255:0] result;
   logic [4:0]   flags;

   int checks = 0;
   int errors = 0;
   logic [255:0] exp_res = '0;
   logic [4:0]   exp_flags = '0;

   always #10 clk = ~clk;

   hsub_unit uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
      .src1(src1), .src2(src2), .src2_mem(src2_mem), .src2_addr(src2_addr),
      .flags_clr(flags_clr), .out_valid(out_valid), .result(result),
      .fault_gp(fault_gp), .flags(flags)
   );

   task automatic chk(input string tag, input string what,
                      input logic [255:0] act, input logic [255:0] expv);
      checks++;
      if (act !== expv) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
      end
   endtask

   // reference for one lane: a - b
   task automatic ref_lane(input logic [63:0] a, input logic [63:0] b,
                           output logic [63:0] r, output logic [4:0] f);
      logic an, bn, ai, bi, ad, bd;
      real ra, rb, rs, bp, ap, er;
      f  = '0;
      an = (a[62:52] == 11'h7FF) && (a[51:0] != 0);
      bn = (b[62:52] == 11'h7FF) && (b[51:0] != 0);
      ai = (a[62:52] == 11'h7FF) && (a[51:0] == 0);
      bi = (b[62:52] == 11'h7FF) && (b[51:0] == 0);
      ad = (a[62:52] == 0) && (a[51:0] != 0);
      bd = (b[62:52] == 0) && (b[51:0] != 0);
      if (an || bn) begin
         r = an ? (a | 64'h0008_0000_0000_0000) : (b | 64'h0008_0000_0000_0000);
         f[0] = (an && !a[51]) || (bn && !b[51]);
      end else begin
         f[1] = ad | bd;
         if (ai && bi && (a[63] == b[63])) begin
            r = 64'hFFF8_0000_0000_0000;
            f[0] = 1'b1;
         end else if (ai) r = a;
         else if (bi) r = {~b[63], b[62:0]};
         else begin
            ra = $bitstoreal(a);
            rb = $bitstoreal(b);
            rs = ra - rb;
            r  = $realtobits(rs);
            if (r[62:52] == 11'h7FF) begin
               f[2] = 1'b1;
               f[4] = 1'b1;
            end else begin
               bp = rs - ra;
               ap = rs - bp;
               er = (ra - ap) + ((-rb) - bp);
               f[4] = (er != 0.0);
               f[3] = f[4] && (r[62:52] == 0);
            end
         end
      end
   endtask

   task automatic ref_vec(input logic [1:0] m, input logic [255:0] s1, input logic [255:0] s2,
                          input logic mem, input logic [47:0] addr,
                          output logic [255:0] r, output logic [4:0] f, output logic flt);
      logic [63:0] lr;
      logic [4:0]  lf;
      flt = (m == 2'b00) && mem && (addr[3:0] != 0);
      f = '0;
      r = '0;
      for (int c = 0; c < 2; c++) begin
         ref_lane(s1[c*128 +: 64], s1[c*128+64 +: 64], lr, lf);
         if (c == 0 || m[1]) begin r[c*128 +: 64] = lr; f = f | lf; end
         ref_lane(s2[c*128 +: 64], s2[c*128+64 +: 64], lr, lf);
         if (c == 0 || m[1]) begin r[c*128+64 +: 64] = lr; f = f | lf; end
      end
      if (!m[1]) r[255:128] = (m == 2'b00) ? s1[255:128] : '0;
      if (flt) begin r = s1; f = '0; end
   endtask

   task automatic do_op(input string tag, input logic [1:0] m, input logic [255:0] s1,
                        input logic [255:0] s2, input logic mem, input logic [47:0] addr,
                        input logic clr);
      logic [255:0] er;
      logic [4:0]   ef;
      logic         eflt;
      mode = m; src1 = s1; src2 = s2; src2_mem = mem; src2_addr = addr;
      flags_clr = clr; in_valid = 1'b1;
      ref_vec(m, s1, s2, mem, addr, er, ef, eflt);
      @(posedge clk);
      exp_flags = (clr ? 5'b0 : exp_flags) | ef;
      exp_res = er;
      @(negedge clk);
      chk(tag, "result", result, exp_res);
      chk(tag, "fault_gp", {255'b0, fault_gp}, {255'b0, eflt});
      chk("R11", "flags", {251'b0, flags}, {251'b0, exp_flags});
      chk("R12", "out_valid", {255'b0, out_valid}, 256'd1);
   endtask

   task automatic idle_cycle();
      in_valid = 1'b0; flags_clr = 1'b0;
      src1 = {8{$urandom}}; src2 = {8{$urandom}}; mode = 2'($urandom);
      @(posedge clk);
      @(negedge clk);
      chk("R12", "idle out_valid", {255'b0, out_valid}, '0);
      chk("R12", "idle result hold", result, exp_res);
      chk("R12", "idle flags hold", {251'b0, flags}, {251'b0, exp_flags});
   endtask

   function automatic logic [255:0] pk(input logic [63:0] l0, input logic [63:0] l1,
                                       input logic [63:0] l2, input logic [63:0] l3);
      return {l3, l2, l1, l0};
   endfunction

   function automatic logic [63:0] rnd_op(input logic [63:0] base);
      logic        s;
      logic [51:0] fr;
      s  = 1'($urandom);
      fr = {$urandom, $urandom};
      case ($urandom % 10)
         0: return {base[63:20], 20'($urandom)};
         1: return {s, base[62:0]};
         2: return {$urandom, $urandom};
         3: return {s, 11'h000, fr};
         4: return {s, 63'h0};
         5: return {s, 11'h7FF, 52'h0};
         6: return {s, 11'h7FE - 11'($urandom % 3), fr};
         7: return {s, 11'h7FF, fr};
         8: return {s, 11'(1023 + ($urandom % 64) - 32), fr};
         default: return {s, 11'(1000 + ($urandom % 48)), fr};
      endcase
   endfunction

   localparam logic [63:0] ONE  = 64'h3FF0_0000_0000_0000;
   localparam logic [63:0] QDEF = 64'hFFF8_0000_0000_0000;

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL R12 watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [255:0] s1, s2;
      logic [63:0]  lo;
      void'($urandom(32'd4177));
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R12", "reset out_valid", {255'b0, out_valid}, '0);
      chk("R12", "reset result", result, '0);
      chk("R12", "reset fault", {255'b0, fault_gp}, '0);
      chk("R11", "reset flags", {251'b0, flags}, '0);
      rst_n = 1'b1;

      // R1: 3.0 - 1.0 = 2.0, 10.0 - 4.0 = 6.0
      do_op("R1", 2'b01, pk($realtobits(3.0), ONE, ONE, ONE),
            pk($realtobits(10.0), $realtobits(4.0), 0, 0), 1'b0, '0, 1'b0);
      chk("R1", "lane0", result[63:0], 64'h4000_0000_0000_0000);
      chk("R1", "lane1", result[127:64], 64'h4018_0000_0000_0000);
      // R2: wide, no cross-section mixing
      do_op("R2", 2'b10, pk(ONE, ONE, $realtobits(5.0), $realtobits(2.0)),
            pk(ONE, ONE, $realtobits(1.0), $realtobits(9.0)), 1'b1, 48'h7, 1'b0);
      chk("R2", "lane2", result[191:128], $realtobits(3.0));
      chk("R2", "lane3", result[255:192], $realtobits(-8.0));
      // R3 keep upper, R4 zero upper
      s1 = pk(ONE, ONE, 64'h1234_5678_9ABC_DEF0, 64'h0FED_CBA9_8765_4321);
      do_op("R3", 2'b00, s1, s1, 1'b1, 48'h10, 1'b0);
      chk("R3", "upper kept", result[255:128], s1[255:128]);
      do_op("R4", 2'b01, s1, s1, 1'b1, 48'h3, 1'b0);
      chk("R4", "upper zero", result[255:128], '0);
      // R5 fault: misaligned in keep mode with sNaN that must not raise flags
      s1 = pk(64'h7FF0_0000_0000_0001, ONE, 64'hAAAA, 64'h5555);
      do_op("R5", 2'b00, s1, s1, 1'b1, 48'h1008, 1'b1);
      chk("R5", "fault result src1", result, s1);
      chk("R5", "fault no flags", {251'b0, flags}, '0);
      do_op("R5", 2'b10, s1, s1, 1'b1, 48'h1008, 1'b1);
      chk("R5", "no fault wide", {255'b0, fault_gp}, '0);
      // R6 ties to even
      do_op("R6", 2'b01, pk(64'h4340_0000_0000_0000, 64'hBFF0_0000_0000_0000, 0, 0),
            pk(64'h4340_0000_0000_0001, 64'hBFF0_0000_0000_0000, 0, 0), 1'b0, '0, 1'b1);
      chk("R6", "tie down", result[63:0], 64'h4340_0000_0000_0000);
      chk("R6", "tie up", result[127:64], 64'h4340_0000_0000_0002);
      do_op("R6", 2'b01, pk(ONE, ONE, 0, 0),
            pk(64'h8000_0000_0000_0000, 64'h0, 0, 0), 1'b0, '0, 1'b1);
      chk("R6", "x-x=+0", result[63:0], 64'h0);
      chk("R6", "-0-+0", result[127:64], 64'h8000_0000_0000_0000);
      // R7 NaN priority / quieting, R8 inf-inf
      do_op("R7", 2'b01, pk(64'hFFF0_0000_0000_0005, 64'h7FF8_0000_0000_0009, 0, 0),
            pk(ONE, 64'h7FF0_0000_0000_0003, 0, 0), 1'b0, '0, 1'b1);
      chk("R7", "low NaN first", result[63:0], 64'hFFF8_0000_0000_0005);
      chk("R7", "high NaN quiet", result[127:64], 64'h7FF8_0000_0000_0003);
      chk("R7", "invalid", {255'b0, flags[0]}, 256'd1);
      do_op("R8", 2'b01, pk(64'h7FF0_0000_0000_0000, 64'h7FF0_0000_0000_0000, 0, 0),
            pk(ONE, 64'h7FF0_0000_0000_0000, 0, 0), 1'b0, '0, 1'b1);
      chk("R8", "inf-inf", result[63:0], QDEF);
      chk("R8", "1-inf", result[127:64], 64'hFFF0_0000_0000_0000);
      // R9 overflow
      do_op("R9", 2'b01, pk(64'h7FEF_FFFF_FFFF_FFFF, 64'hFFEF_FFFF_FFFF_FFFF, 0, 0),
            pk(ONE, ONE, 0, 0), 1'b0, '0, 1'b1);
      chk("R9", "inf out", result[63:0], 64'h7FF0_0000_0000_0000);
      chk("R9", "ofl+prec", {251'b0, flags}, 256'h14);
      // R10 subnormal difference: denormal set, underflow clear
      do_op("R10", 2'b01, pk(64'h0000_0000_0000_0003, 64'h0000_0000_0000_0001, 0, 0),
            pk(ONE, ONE, 0, 0), 1'b0, '0, 1'b1);
      chk("R10", "subnormal diff", result[63:0], 64'h2);
      chk("R10", "den only", {251'b0, flags}, 256'h2);
      // R11 inactive upper lanes do not raise flags; sticky then clear
      do_op("R11", 2'b01, pk(ONE, ONE, 64'h7FF0_0000_0000_0001, ONE),
            pk(ONE, ONE, 64'h0000_0000_0000_0001, ONE), 1'b0, '0, 1'b1);
      chk("R11", "inactive lanes", {251'b0, flags}, '0);
      do_op("R11", 2'b01, pk(ONE, 64'h3C00_0000_0000_0000, 0, 0), '0, 1'b0, '0, 1'b0);
      do_op("R11", 2'b01, pk(ONE, ONE, 0, 0), '0, 1'b0, '0, 1'b0);
      chk("R11", "sticky prec", {251'b0, flags}, 256'h10);
      do_op("R11", 2'b01, pk(ONE, ONE, 0, 0), '0, 1'b0, '0, 1'b1);
      chk("R11", "cleared", {251'b0, flags}, '0);
      idle_cycle();

      for (int n = 0; n < 1500; n++) begin
         logic [1:0] m;
         m = 2'($urandom);
         for (int c = 0; c < 4; c++) begin
            lo = rnd_op({1'b0, 11'(1020 + $urandom % 8), 52'($urandom)});
            s1[c*64 +: 64] = lo;
            s2[c*64 +: 64] = rnd_op(lo);
         end
         for (int c = 0; c < 2; c++) begin
            s1[c*128+64 +: 64] = rnd_op(s1[c*128 +: 64]);
            s2[c*128 +: 64]    = rnd_op(s2[c*128+64 +: 64]);
         end
         do_op(m[1] ? "R2" : (m == 2'b00 ? "R3" : "R4"), m, s1, s2, 1'($urandom),
               {44'($urandom), (($urandom % 4) == 0) ? 4'($urandom) : 4'h0},
               (($urandom % 8) == 0));
         if (($urandom % 16) == 0) idle_cycle();
      end

      in_valid = 1'b0;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule